// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This unit forms a 32-bit operand address for indexed addressing modes. It takes a base value from the decoder, reads the index register straight from the register file bus, and pulls extension words from the prefetch stream over a request/acknowledge handshake. The first word pulled is the index extension word. In the short (brief) format that one word is the whole story. In the full format the word can call for more displacement words, suppress the base or the index, and request one 32-bit memory read through a second handshake. The index can be added either before or after that read.

The decoder pulses `start` with the base on `base_in`. It then waits for `done`, which carries the final address on `ea_out` and the number of internal steps taken on `steps_out`. Steps count displacement fetches, the index addition and the memory read, and they let a cycle-accurate core charge the right timing.

The controller moves through these states:
- `ST_IDLE` goes to `ST_EXT` when `start` is accepted.
- `ST_EXT` fetches the extension word. In brief format it goes to `ST_DONE`. In full format it goes to `ST_BD_W1` when a base displacement is present, else to `ST_OD_W1` when an outer displacement is present, else to `ST_SUM`.
- `ST_BD_W1` goes to `ST_BD_W2` for a long base displacement. Otherwise it continues as `ST_EXT` would for the outer displacement.
- `ST_BD_W2` continues the same way after the second word.
- `ST_OD_W1` goes to `ST_OD_W2` for a long outer displacement, else to `ST_SUM`.
- `ST_OD_W2` goes to `ST_SUM`.
- `ST_SUM` goes to `ST_MEM` when the indirect field is nonzero, else to `ST_DONE`.
- `ST_MEM` goes to `ST_DONE` on `mem_ack`.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `eaix_unit`

## Requirements
- R1: With extension bit 8 clear (brief format), the result is base plus the sign-extended bits 7:0 plus the scaled index, and the step count is 0. No further extension word or memory read is requested.
- R2: Extension bits 15:12 pick the index register: values 0–7 are data registers 0–7 and values 8–15 are address registers 0–7. Register k sits at `regs_in[32k+31:32k]`. Bit 11 set uses all 32 bits. Bit 11 clear uses the low 16 bits sign-extended.
- R3: Extension bits 10:9 shift the index left by 0, 1, 2 or 3 places.
- R4: In full format (bit 8 set), bit 7 replaces the base with zero and bit 6 replaces the index with zero.
- R5: Full-format bits 5:4 choose the base displacement: 2'b10 fetches one sign-extended word, 2'b11 fetches two words (high half first), and 2'b00 or 2'b01 fetch nothing. Exactly that many extension words follow the first.
- R6: Full-format bits 1:0 choose the outer displacement with the same encoding as bits 5:4, fetched after the base displacement. The outer displacement is added last.
- R7: When full-format bits 1:0 are nonzero, exactly one 32-bit read is made at the intermediate address. With bit 2 clear, that address includes the index. With bit 2 set, the index is added to the read data instead.
- R8: In full format the step count is one per displacement present, plus one for the index addition, plus one for the memory read.
- R9: After reset the unit is idle with `busy`, `done`, `ext_req` and `mem_req` low. `start` is accepted only while idle. `busy` stays high from acceptance through the `done` cycle and is low in the cycle after it.
- R10: `done` is a single-cycle pulse, and `ea_out` and `steps_out` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a calculation (accepted only when idle) |
| base_in | input | 32 | Base register value, sampled at acceptance |
| regs_in | input | 512 | Sixteen 32-bit registers: data 0–7, then address 0–7 |
| busy | output | 1 | Calculation in progress |
| ext_req | output | 1 | Extension word wanted |
| ext_ack | input | 1 | Extension word valid on `ext_word` |
| ext_word | input | 16 | Extension word from the prefetch stream |
| mem_req | output | 1 | Memory read wanted |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid on `mem_data` |
| mem_data | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| ea_out | output | 32 | Computed effective address |
| steps_out | output | 3 | Internal step count for this calculation |

## Verification
The bench uses the default parameters: a 16-bit extension word, which makes the address 32 bits, sixteen registers, and a 3-bit step count. With these values a long displacement arrives as two halves, so the word ordering inside the handshake is exercised. Every index register number from 0 to 15 can be selected, and the largest count of 4 fits with headroom. Each indirect case reads from a bench memory whose contents are a function of the address. A read made at the wrong intermediate address, with the index added on the wrong side, therefore yields a different final address.

// File: rtl/eaix_pkg.sv
`timescale 1ns/1ps
package eaix_pkg;
    // Field positions inside the extension word (decoded by this unit)
    localparam int XB_SEL_LO  = 12;
    localparam int XB_LONGIX  = 11;
    localparam int XB_SCL_LO  = 9;
    localparam int XB_FULL    = 8;
    localparam int XB_NOBASE  = 7;
    localparam int XB_NOIDX   = 6;
    localparam int XB_BD_LO   = 4;
    localparam int XB_POST    = 2;
    localparam int XB_OD_LO   = 0;

    localparam logic [1:0] DSZ_WORD = 2'b10;
    localparam logic [1:0] DSZ_LONG = 2'b11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EXT,
        ST_BD_W1,
        ST_BD_W2,
        ST_OD_W1,
        ST_OD_W2,
        ST_SUM,
        ST_MEM,
        ST_DONE
    } eaix_state_t;

    typedef struct packed {
        logic       full;
        logic       post;
        logic [1:0] bd;
        logic [1:0] od;
    } eaix_fmt_t;
endpackage

// File: rtl/eaix_index.sv
`timescale 1ns/1ps
module eaix_index #(
    parameter int WORD_W = 16,
    parameter int NREGS  = 16,
    localparam int AW    = 2 * WORD_W,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic [NREGS*AW-1:0] regs_flat,
    input  logic [SEL_W-1:0]    sel,
    input  logic                long_sel,
    input  logic [1:0]          scale,
    output logic [AW-1:0]       scaled
);
    logic [AW-1:0] bank [NREGS];
    logic [AW-1:0] raw;
    logic [AW-1:0] sized;

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_unpack
            assign bank[g] = regs_flat[g*AW +: AW];
        end
    endgenerate

    assign raw    = bank[sel];
    assign sized  = long_sel ? raw : {{WORD_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
    assign scaled = sized << scale;
endmodule

// File: rtl/eaix_disp.sv
`timescale 1ns/1ps
module eaix_disp #(
    parameter int WORD_W = 16,
    localparam int AW    = 2 * WORD_W
) (
    input  logic [WORD_W-1:0] hi_half,
    input  logic [WORD_W-1:0] word,
    input  logic              is_long,
    output logic [AW-1:0]     value
);
    assign value = is_long ? {hi_half, word} : {{WORD_W{word[WORD_W-1]}}, word};
endmodule

// File: rtl/eaix_steps.sv
`timescale 1ns/1ps
module eaix_steps #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    // R8
    steps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/eaix_unit.sv
`timescale 1ns/1ps
module eaix_unit
    import eaix_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NREGS  = 16,
    parameter int STEP_W = 3,
    localparam int AW    = 2 * WORD_W,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [AW-1:0]       base_in,
    input  logic [NREGS*AW-1:0] regs_in,
    output logic                busy,
    output logic                ext_req,
    input  logic                ext_ack,
    input  logic [WORD_W-1:0]   ext_word,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    input  logic                mem_ack,
    input  logic [AW-1:0]       mem_data,
    output logic                done,
    output logic [AW-1:0]       ea_out,
    output logic [STEP_W-1:0]   steps_out
);
    eaix_state_t       state, nstate;
    eaix_fmt_t         fmt_q;
    logic [AW-1:0]     base_q, acc, idx_q, outer_q, ea_q;
    logic [WORD_W-1:0] dhi;
    logic [AW-1:0]     idx_now, disp_val, pre_sum;
    logic              disp_long, step_inc, step_clr;

    eaix_index #(.WORD_W(WORD_W), .NREGS(NREGS)) u_index (
        .regs_flat (regs_in),
        .sel       (ext_word[XB_SEL_LO +: SEL_W]),
        .long_sel  (ext_word[XB_LONGIX]),
        .scale     (ext_word[XB_SCL_LO +: 2]),
        .scaled    (idx_now)
    );

    assign disp_long = (state == ST_BD_W2) || (state == ST_OD_W2);

    eaix_disp #(.WORD_W(WORD_W)) u_disp (
        .hi_half (dhi),
        .word    (ext_word),
        .is_long (disp_long),
        .value   (disp_val)
    );

    assign step_clr = (state == ST_IDLE) && start;
    assign step_inc = ((state == ST_BD_W1) && ext_ack && (fmt_q.bd != DSZ_LONG))
                   || ((state == ST_BD_W2) && ext_ack)
                   || ((state == ST_OD_W1) && ext_ack && (fmt_q.od != DSZ_LONG))
                   || ((state == ST_OD_W2) && ext_ack)
                   || (state == ST_SUM)
                   || ((state == ST_MEM) && mem_ack);

    eaix_steps #(.CW(STEP_W)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (step_clr),
        .inc   (step_inc),
        .count (steps_out)
    );

    function automatic eaix_state_t after_od(input logic [1:0] od);
        return od[1] ? ST_OD_W1 : ST_SUM;
    endfunction

    function automatic eaix_state_t after_bd(input logic [1:0] bd, input logic [1:0] od);
        return bd[1] ? ST_BD_W1 : after_od(od);
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start) nstate = ST_EXT;
            ST_EXT:   if (ext_ack)
                          nstate = ext_word[XB_FULL]
                                 ? after_bd(ext_word[XB_BD_LO +: 2], ext_word[XB_OD_LO +: 2])
                                 : ST_DONE;
            ST_BD_W1: if (ext_ack)
                          nstate = (fmt_q.bd == DSZ_LONG) ? ST_BD_W2 : after_od(fmt_q.od);
            ST_BD_W2: if (ext_ack) nstate = after_od(fmt_q.od);
            ST_OD_W1: if (ext_ack)
                          nstate = (fmt_q.od == DSZ_LONG) ? ST_OD_W2 : ST_SUM;
            ST_OD_W2: if (ext_ack) nstate = ST_SUM;
            ST_SUM:   nstate = (fmt_q.od != 2'b00) ? ST_MEM : ST_DONE;
            ST_MEM:   if (mem_ack) nstate = ST_DONE;
            ST_DONE:  nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    assign pre_sum = acc + (fmt_q.post ? '0 : idx_q);

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q   <= '0;
            base_q  <= '0;
            acc     <= '0;
            idx_q   <= '0;
            outer_q <= '0;
            ea_q    <= '0;
            dhi     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) base_q <= base_in;
                ST_EXT: if (ext_ack) begin
                    fmt_q.full <= ext_word[XB_FULL];
                    fmt_q.post <= ext_word[XB_POST];
                    fmt_q.bd   <= ext_word[XB_BD_LO +: 2];
                    fmt_q.od   <= ext_word[XB_OD_LO +: 2];
                    outer_q    <= '0;
                    if (ext_word[XB_FULL]) begin
                        acc   <= ext_word[XB_NOBASE] ? '0 : base_q;
                        idx_q <= ext_word[XB_NOIDX]  ? '0 : idx_now;
                    end else begin
                        ea_q <= base_q + {{(AW-8){ext_word[7]}}, ext_word[7:0]} + idx_now;
                    end
                end
                ST_BD_W1: if (ext_ack) begin
                    if (fmt_q.bd == DSZ_LONG) dhi <= ext_word;
                    else                      acc <= acc + disp_val;
                end
                ST_BD_W2: if (ext_ack) acc <= acc + disp_val;
                ST_OD_W1: if (ext_ack) begin
                    if (fmt_q.od == DSZ_LONG) dhi     <= ext_word;
                    else                      outer_q <= disp_val;
                end
                ST_OD_W2: if (ext_ack) outer_q <= disp_val;
                ST_SUM: begin
                    if (fmt_q.od != 2'b00) acc <= pre_sum;
                    else ea_q <= pre_sum + (fmt_q.post ? idx_q : '0) + outer_q;
                end
                ST_MEM: if (mem_ack)
                    ea_q <= mem_data + (fmt_q.post ? idx_q : '0) + outer_q;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        ext_req  = (state == ST_EXT) || (state == ST_BD_W1) || (state == ST_BD_W2)
                || (state == ST_OD_W1) || (state == ST_OD_W2);
        mem_req  = (state == ST_MEM);
        done     = (state == ST_DONE);
        mem_addr = acc;
        ea_out   = ea_q;
    end

    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R5
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> ext_req);
    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R8
    steps_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (steps_out <= STEP_W'(4)));
    // R1
    brief_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fmt_q.full) |-> (steps_out == '0));
    // R7
    one_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_req, mem_req, done}));
endmodule

// File: tb/eaix_unit_test.sv
`timescale 1ns/1ps
module eaix_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  base_in = '0;
    logic [511:0] regs_in = '0;
    logic         busy, ext_req, mem_req, done;
    logic         ext_ack = 1'b0;
    logic [15:0]  ext_word = '0;
    logic [31:0]  mem_addr;
    logic         mem_ack = 1'b0;
    logic [31:0]  mem_data = '0;
    logic [31:0]  ea_out;
    logic [2:0]   steps_out;

    int total = 0;
    int fails = 0;
    logic [31:0] rv [16];

    always #2.5 clk = ~clk;

    eaix_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in), .regs_in(regs_in),
        .busy(busy), .ext_req(ext_req), .ext_ack(ext_ack), .ext_word(ext_word),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .done(done), .ea_out(ea_out), .steps_out(steps_out)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
    endfunction

    function automatic void model(input logic [31:0] base, input logic [15:0] x,
                                  input logic [63:0] dw, output logic [31:0] ea,
                                  output int st, output int nw, output int nrd,
                                  output logic [31:0] ma);
        logic [31:0] iv, b, outer;
        logic [15:0] w [4];
        int p;
        w[0] = dw[63:48]; w[1] = dw[47:32]; w[2] = dw[31:16]; w[3] = dw[15:0];
        iv = rv[x[15:12]];
        if (!x[11]) iv = {{16{iv[15]}}, iv[15:0]};
        iv = iv << x[10:9];
        st = 0; nw = 0; nrd = 0; ma = '0; outer = '0; p = 0;
        if (!x[8]) begin
            ea = base + {{24{x[7]}}, x[7:0]} + iv;
            return;
        end
        b = x[7] ? 32'h0 : base;
        if (x[6]) iv = '0;
        if (x[5:4] == 2'b10) begin b = b + {{16{w[p][15]}}, w[p]}; p++; st++; end
        else if (x[5:4] == 2'b11) begin b = b + {w[p], w[p+1]}; p += 2; st++; end
        if (x[1:0] == 2'b10) begin outer = {{16{w[p][15]}}, w[p]}; p++; st++; end
        else if (x[1:0] == 2'b11) begin outer = {w[p], w[p+1]}; p += 2; st++; end
        if (!x[2]) begin b = b + iv; st++; end
        if (x[1:0] != 2'b00) begin ma = b; b = memval(b); st++; nrd = 1; end
        if (x[2]) begin b = b + iv; st++; end
        ea = b + outer;
        nw = p;
    endfunction

    task automatic run_op(input string rq, input logic [31:0] base, input logic [15:0] x,
                          input logic [63:0] dw, input bit poke);
        logic [31:0] e_ea, e_ma, g_ea, g_ma;
        int e_st, e_nw, e_nrd, g_nrd, qi, cyc;
        logic [2:0] g_st;
        logic [15:0] q [8];
        bit got, busy_ok;
        model(base, x, dw, e_ea, e_st, e_nw, e_nrd, e_ma);
        q[0] = x; q[1] = dw[63:48]; q[2] = dw[47:32]; q[3] = dw[31:16]; q[4] = dw[15:0];
        q[5] = 16'hDEAD; q[6] = 16'hDEAD; q[7] = 16'hDEAD;
        @(negedge clk); base_in = base; start = 1'b1;
        @(negedge clk); start = 1'b0;
        qi = 0; g_nrd = 0; got = 0; busy_ok = 1; cyc = 0; g_ea = '0; g_st = '0; g_ma = '0;
        while (!got && cyc < 200) begin
            if (done) begin
                got = 1; g_ea = ea_out; g_st = steps_out;
                ext_ack = 1'b0; mem_ack = 1'b0; start = 1'b0;
            end else begin
                if (!busy) busy_ok = 0;
                ext_ack = ext_req;
                if (ext_req) begin ext_word = q[qi & 7]; qi++; end
                mem_ack = mem_req;
                if (mem_req) begin g_ma = mem_addr; mem_data = memval(mem_addr); g_nrd++; end
                start = (poke && cyc == 1);
                @(negedge clk); cyc++;
            end
        end
        if (!got) begin
            total++; fails++;
            $display("FAIL R10 no done: actual 0 expected 1");
            return;
        end
        chk(rq, "address", g_ea, e_ea);
        chk("R8", "step count", {29'h0, g_st}, e_st);
        chk("R5", "extension words used", qi, e_nw + 1);
        chk("R7", "memory reads", g_nrd, e_nrd);
        if (e_nrd != 0) chk("R7", "read address", g_ma, e_ma);
        chk("R9", "busy until done", {31'h0, busy_ok}, 32'h1);
        @(negedge clk);
        chk("R10", "done width", {31'h0, done}, 32'h0);
        chk("R9", "busy after done", {31'h0, busy}, 32'h0);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                chk("R9", "start while busy ignored", {30'h0, busy, ext_req}, 32'h0);
            end
        end
    endtask

    // R1 R2 R3: brief, word data index (negative), scale x4, negative byte
    task automatic t_brief_word();
        run_op("R1", 32'h2000_0000, 16'h34F8, 64'h0, 0);
    endtask
    // R2 R3: brief, long address index, scale x8
    task automatic t_brief_long();
        run_op("R2", 32'h0004_0000, 16'hDE10, 64'h0, 0);
    endtask
    // R4: base and index both suppressed, null displacement
    task automatic t_suppress();
        run_op("R4", 32'h7777_7777, 16'h01D0, 64'h0, 0);
    endtask
    // R5: negative word base displacement, long index scale x2
    task automatic t_bd_word();
        run_op("R5", 32'h0010_0000, 16'hDB20, {16'h8000, 48'h0}, 0);
    endtask
    // R6 R7: long base and outer displacements, pre-index indirect
    task automatic t_pre_long();
        run_op("R6", 32'h0300_0000, 16'h3133, 64'h0012_3456_FFFF_FFFE, 0);
    endtask
    // R7: post-index indirect, word base and outer displacement
    task automatic t_post_word();
        run_op("R7", 32'h0500_0000, 16'hDD26, {16'h0100, 16'h7FFF, 32'h0}, 0);
    endtask
    // R7 R4: post-index indirect with no outer displacement, base suppressed
    task automatic t_post_null();
        run_op("R7", 32'h1234_5678, 16'h5195, 64'h0, 0);
    endtask
    // R9: start pulsed mid-calculation is ignored
    task automatic t_busy_poke();
        run_op("R1", 32'h0000_1000, 16'h0F7F, 64'h0, 1);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) rv[k] = 32'h0100_0000 + k * 32'h0000_0111;
        rv[3]  = 32'h0001_FFF0;
        rv[13] = 32'h0000_1234;
        rv[5]  = 32'h8000_0040;
        for (int k = 0; k < 16; k++) regs_in[k*32 +: 32] = rv[k];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "reset outputs", {28'h0, busy, done, ext_req, mem_req}, 32'h0);
        chk("R9", "reset steps", {29'h0, steps_out}, 32'h0);
        t_brief_word();
        t_brief_long();
        t_suppress();
        t_bd_word();
        t_pre_long();
        t_post_word();
        t_post_null();
        t_busy_poke();
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end
endmodule